// File: doc/BRIEF.md
# Alternating Two-Bank Frame Receive Store

This block takes frames from a MAC receive stream (one byte per cycle with valid, last and error flags) and writes each one into one of two on-chip receive banks, called ping and pong. When an error-free frame has been fully written, the block sets a done flag in that bank's status word. It can also raise an interrupt pulse. Software reads the frame and the status words through a 32-bit register port. It hands the bank back by writing the status word with the done bit cleared.

A bank that holds an unacknowledged frame stays locked. Frames go strictly to ping, then pong, then ping again. If the bank that is next in turn is still locked, the incoming frame is discarded and a drop counter advances. When the pong bank is disabled by a parameter, every frame goes to ping.

Top module: `rx_pingpong_ctrl`

## Requirements
- R1: After reset, the done and interrupt-enable flags of both banks are clear, `irq` is low, `drop_count` is 0, and the first frame goes to the ping bank.
- R2: Byte i of a stored frame sits at byte offset i of its bank, packed into 32-bit words with the lowest offset in bits 7:0. Bytes after the frame end in its last word read as zero. The ping bank starts at byte address 0x1000 and the pong bank at 0x1800. Address bit 11 selects pong, and bits 10:2 select the word.
- R3: Done (status bit 0) of the target bank is set at the clock edge that takes the last byte of an accepted, error-free frame. The status words are at 0x17FC (ping) and 0x1FFC (pong). They read back interrupt-enable at bit 3, done at bit 0, and zero in all other bits.
- R4: Writing a status word with bit 0 at 0 clears done. Writing it with bit 0 at 1 leaves done unchanged. Bit 3 of the written value loads interrupt-enable.
- R5: With pong enabled, completed frames alternate ping, pong, ping and so on. Only a frame that sets done moves the sequence on.
- R6: With pong disabled, every frame goes to ping. The pong region, its status word included, reads as zero, and writes to it are ignored.
- R7: A frame that arrives while the next bank in turn still has done set is discarded. The contents and status of both banks are unchanged, `drop_count` rises by one, and the sequence does not advance.
- R8: A frame with `rx_err` high on any of its bytes does not set done and does not advance the sequence, so the next frame goes to the same bank.
- R9: Bytes beyond the bank's data area (the first 2044 bytes) are not stored. The stored part is kept, done is still set, and the status word is never overwritten by frame data.
- R10: `irq` is high for exactly one cycle, at the same edge at which a bank's done rises, and only when that bank's interrupt-enable is set.
- R11: For a read request sampled at a clock edge, `bus_rvalid` and `bus_rdata` are valid after the second edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` is valid this cycle |
| rx_last | input | 1 | Current byte is the last of the frame |
| rx_err | input | 1 | Frame is in error (sampled on any byte) |
| bus_addr | input | 13 | Byte address of register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| irq | output | 1 | One-cycle receive interrupt pulse |
| drop_count | output | 16 | Count of frames discarded for lack of a free bank |

## Verification
The status and interrupt results of a frame are due at the edge that takes its last byte. The bench drives every input on a falling edge and checks `irq`, `drop_count` and the status words at the falling edge right after that capture edge. It then checks one cycle later that `irq` has returned low. A register read is checked exactly two falling edges after its request, where `bus_rvalid` must be high, and the data is compared at that point. Data checks after a dropped or failed frame are made before any new frame starts, so a bank that was wrongly touched is still visible.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  localparam int ST_DONE_BIT = 0;
  localparam int ST_IE_BIT   = 3;

  function automatic logic [31:0] merge_byte(input logic [1:0] lane,
                                             input logic [7:0] b,
                                             input logic [23:0] acc);
    logic [31:0] w;
    case (lane)
      2'd0:    w = {24'd0, b};
      2'd1:    w = {16'd0, b, acc[7:0]};
      2'd2:    w = {8'd0, b, acc[15:0]};
      default: w = {b, acc};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/rxpp_bufmem.sv
module rxpp_bufmem #(
  parameter int DW = 32,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxpp_fill.sv
module rxpp_fill
  import rxpp_pkg::*;
#(
  parameter int IDX_W      = 9,
  parameter int DATA_WORDS = 511
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  input  logic             rx_last,
  input  logic             rx_err,
  input  logic             next_sel,
  input  logic             tgt_busy,
  output logic             wr_en,
  output logic             wr_buf,
  output logic [IDX_W-1:0] wr_idx,
  output logic [31:0]      wr_word,
  output logic             frame_ok,
  output logic             frame_drop
);
  logic             in_frame, keep, bad, tgt;
  logic [1:0]       lane;
  logic [IDX_W-1:0] widx;
  logic [23:0]      acc;

  logic             sof, acc_now, bad_cur, full;
  logic [1:0]       cur_lane;
  logic [IDX_W-1:0] cur_widx;

  always_comb begin
    sof      = rx_valid && !in_frame;
    acc_now  = sof ? !tgt_busy : keep;
    bad_cur  = sof ? 1'b0 : bad;
    cur_lane = sof ? 2'd0 : lane;
    cur_widx = sof ? '0 : widx;
    full     = (cur_widx == IDX_W'(DATA_WORDS));
    wr_buf   = sof ? next_sel : tgt;
    wr_idx   = cur_widx;
    wr_word  = merge_byte(cur_lane, rx_data, acc);
    wr_en    = rx_valid && acc_now && !full && (cur_lane == 2'd3 || rx_last);
    frame_ok = rx_valid && rx_last && acc_now && !(bad_cur || rx_err);
    frame_drop = sof && tgt_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      keep     <= 1'b0;
      bad      <= 1'b0;
      tgt      <= 1'b0;
      lane     <= 2'd0;
      widx     <= '0;
      acc      <= '0;
    end else if (rx_valid) begin
      in_frame <= !rx_last;
      keep     <= acc_now;
      bad      <= bad_cur || rx_err;
      tgt      <= wr_buf;
      lane     <= cur_lane + 2'd1;
      acc      <= wr_word[23:0];
      widx     <= (cur_lane == 2'd3 && !full) ? cur_widx + 1'b1 : cur_widx;
    end
  end
endmodule

// File: rtl/rxpp_stat.sv
module rxpp_stat #(
  parameter bit PONG_EN = 1'b1,
  parameter int DROP_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_ok,
  input  logic              frame_drop,
  input  logic              ok_buf,
  input  logic              sw_we,
  input  logic              sw_buf,
  input  logic              sw_keep_done,
  input  logic              sw_ie,
  output logic [1:0]        done,
  output logic [1:0]        ie,
  output logic              next_sel,
  output logic              irq,
  output logic [DROP_W-1:0] drop_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= '0;
      ie       <= '0;
      next_sel <= 1'b0;
      irq      <= 1'b0;
      drop_cnt <= '0;
    end else begin
      irq <= 1'b0;
      if (sw_we) begin
        ie[sw_buf] <= sw_ie;
        if (!sw_keep_done) done[sw_buf] <= 1'b0;
      end
      if (frame_ok) begin
        done[ok_buf] <= 1'b1;
        irq          <= ie[ok_buf];
        if (PONG_EN) next_sel <= !next_sel;
      end
      if (frame_drop) drop_cnt <= drop_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_pingpong_ctrl.sv
module rx_pingpong_ctrl
  import rxpp_pkg::*;
#(
  parameter bit PONG_EN = 1'b1,
  parameter int BUF_AW  = 11,
  parameter int DROP_W  = 16,
  localparam int ADDR_W = BUF_AW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic              rx_err,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              irq,
  output logic [DROP_W-1:0] drop_count
);
  localparam int IDX_W      = BUF_AW - 2;
  localparam int DATA_WORDS = (2 ** IDX_W) - 1;

  logic             wr_en, wr_buf, frame_ok, frame_drop, next_sel;
  logic [IDX_W-1:0] wr_idx;
  logic [31:0]      wr_word;
  logic [1:0]       done_vec, ie_vec;
  logic [31:0]      mem_q [2];

  // Register-port decode
  logic             a_rx, a_buf, a_hit, a_stat;
  logic [IDX_W-1:0] a_idx;
  logic             unused_wbits;

  always_comb begin
    a_rx   = bus_addr[ADDR_W-1];
    a_buf  = bus_addr[ADDR_W-2];
    a_idx  = bus_addr[ADDR_W-3:2];
    a_hit  = a_rx && (!a_buf || PONG_EN);
    a_stat = (a_idx == IDX_W'(DATA_WORDS));
  end
  assign unused_wbits = ^{bus_wdata[31:4], bus_wdata[2:1], bus_addr[1:0]};

  rxpp_fill #(.IDX_W(IDX_W), .DATA_WORDS(DATA_WORDS)) u_fill (
    .clk(clk), .rst(rst),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last), .rx_err(rx_err),
    .next_sel(next_sel), .tgt_busy(done_vec[next_sel]),
    .wr_en(wr_en), .wr_buf(wr_buf), .wr_idx(wr_idx), .wr_word(wr_word),
    .frame_ok(frame_ok), .frame_drop(frame_drop)
  );

  rxpp_stat #(.PONG_EN(PONG_EN), .DROP_W(DROP_W)) u_stat (
    .clk(clk), .rst(rst),
    .frame_ok(frame_ok), .frame_drop(frame_drop), .ok_buf(wr_buf),
    .sw_we(bus_wr && a_hit && a_stat), .sw_buf(a_buf),
    .sw_keep_done(bus_wdata[ST_DONE_BIT]), .sw_ie(bus_wdata[ST_IE_BIT]),
    .done(done_vec), .ie(ie_vec), .next_sel(next_sel),
    .irq(irq), .drop_cnt(drop_count)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    if (b == 0 || PONG_EN) begin : g_on
      rxpp_bufmem #(.DW(32), .AW(IDX_W)) u_mem (
        .clk(clk),
        .we(wr_en && (wr_buf == 1'(b))),
        .waddr(wr_idx), .wdata(wr_word),
        .raddr(a_idx), .rdata(mem_q[b])
      );
    end else begin : g_off
      assign mem_q[b] = '0;
    end
  end

  // Two-stage read: bank RAM output plus selection, then output register
  logic        rd1, hit1, stat1, buf1;
  logic [31:0] stw1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd1        <= 1'b0;
      hit1       <= 1'b0;
      stat1      <= 1'b0;
      buf1       <= 1'b0;
      stw1       <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      rd1   <= bus_rd;
      hit1  <= a_hit;
      stat1 <= a_stat;
      buf1  <= a_buf;
      stw1  <= '0;
      stw1[ST_DONE_BIT] <= done_vec[a_buf];
      stw1[ST_IE_BIT]   <= ie_vec[a_buf];
      bus_rvalid <= rd1;
      if (!rd1 || !hit1) bus_rdata <= '0;
      else if (stat1)    bus_rdata <= stw1;
      else               bus_rdata <= mem_q[buf1];
    end
  end
endmodule

// File: rtl/rxpp_chk.sv
module rxpp_chk #(
  parameter bit PONG_EN = 1'b1,
  parameter int DROP_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              rx_last,
  input logic              rx_err,
  input logic              bus_rd,
  input logic              bus_rvalid,
  input logic              irq,
  input logic [DROP_W-1:0] drop_count,
  input logic [1:0]        done_vec
);
  assert_ping_done_src_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done_vec[0]) |-> $past(rx_valid && rx_last && !rx_err));

  assert_pong_done_src_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done_vec[1]) |-> $past(rx_valid && rx_last && !rx_err));

  assert_err_no_done_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_last && rx_err) |=> !($rose(done_vec[0]) || $rose(done_vec[1])));

  assert_single_bank_R5: assert property (@(posedge clk) disable iff (rst)
    !($rose(done_vec[0]) && $rose(done_vec[1])));

  assert_irq_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($rose(done_vec[0]) || $rose(done_vec[1])));

  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_drop_step_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(drop_count) |-> drop_count == $past(drop_count) + 1'b1);

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> ##1 bus_rvalid);

  always @(posedge clk) begin
    if (!rst && !PONG_EN) assert_no_pong_R6: assert (!done_vec[1]);
  end
endmodule

bind rx_pingpong_ctrl rxpp_chk #(.PONG_EN(PONG_EN), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_last(rx_last), .rx_err(rx_err),
  .bus_rd(bus_rd), .bus_rvalid(bus_rvalid), .irq(irq),
  .drop_count(drop_count), .done_vec(done_vec)
);

// File: tb/sim_rx_pingpong_ctrl.sv
`timescale 1ns/1ps
module sim_rx_pingpong_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [12:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        to1 = 1'b0;

  logic [31:0] rdata0, rdata1;
  logic        rv0, rv1, irq0, irq1;
  logic [15:0] drop0, drop1;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  rx_pingpong_ctrl u0 (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid && !to1),
    .rx_last(rx_last), .rx_err(rx_err), .bus_addr(bus_addr),
    .bus_wr(bus_wr && !to1), .bus_wdata(bus_wdata), .bus_rd(bus_rd && !to1),
    .bus_rdata(rdata0), .bus_rvalid(rv0), .irq(irq0), .drop_count(drop0)
  );

  rx_pingpong_ctrl #(.PONG_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid && to1),
    .rx_last(rx_last), .rx_err(rx_err), .bus_addr(bus_addr),
    .bus_wr(bus_wr && to1), .bus_wdata(bus_wdata), .bus_rd(bus_rd && to1),
    .bus_rdata(rdata1), .bus_rvalid(rv1), .irq(irq1), .drop_count(drop1)
  );

  localparam logic [12:0] PING = 13'h1000, PONG = 13'h1800;
  localparam logic [12:0] PING_ST = 13'h17FC, PONG_ST = 13'h1FFC;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input int seed, input int i);
    return 8'(seed * 16 + i * 3 + 1);
  endfunction

  function automatic logic [31:0] ew(input int seed, input int len, input int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4 * k + j < len) w[8*j +: 8] = fb(seed, 4 * k + j);
    return w;
  endfunction

  task automatic send_frame(input int seed, input int len, input int err_at,
                            input logic exp_irq, input string req);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fb(seed, i);
      rx_last  = (i == len - 1);
      rx_err   = (i == err_at);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    chk({req, " irq at done"}, 32'(to1 ? irq1 : irq0), 32'(exp_irq));
    @(negedge clk);
    chk("R10 irq one cycle", 32'(to1 ? irq1 : irq0), 32'd0);
  endtask

  task automatic bus_read(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
    chk("R11 rvalid after two edges", 32'(to1 ? rv1 : rv0), 32'd1);
    d = to1 ? rdata1 : rdata0;
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [12:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    bus_read(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    chk("R1 irq after reset", 32'(irq0), 32'd0);
    chk("R1 drop after reset", 32'(drop0), 32'd0);
    rd_chk(PING_ST, 32'd0, "R1 ping status reset");
    rd_chk(PONG_ST, 32'd0, "R1 pong status reset");
  endtask

  task automatic t_basic;
    bus_write(PING_ST, 32'h8);
    rd_chk(PING_ST, 32'h8, "R4 ie load");
    send_frame(1, 10, -1, 1'b1, "R10 ping ie set");
    rd_chk(PING_ST, 32'h9, "R3 ping done");
    for (int k = 0; k < 3; k++) rd_chk(PING + 13'(4 * k), ew(1, 10, k), "R2 ping data");
    send_frame(2, 5, -1, 1'b0, "R10 pong ie clear");
    rd_chk(PONG_ST, 32'h1, "R5 second frame to pong");
    rd_chk(PONG + 13'd4, ew(2, 5, 1), "R2 pong data padded");
  endtask

  task automatic t_drop;
    send_frame(3, 7, -1, 1'b0, "R7 drop no irq");
    chk("R7 drop count", 32'(drop0), 32'd1);
    rd_chk(PING, ew(1, 10, 0), "R7 ping data kept");
    rd_chk(PING_ST, 32'h9, "R7 ping status kept");
    rd_chk(PONG + 13'd4, ew(2, 5, 1), "R7 pong data kept");
  endtask

  task automatic t_ack_and_err;
    bus_write(PING_ST, 32'h8);
    rd_chk(PING_ST, 32'h8, "R4 done cleared");
    bus_write(PONG_ST, 32'h1);
    rd_chk(PONG_ST, 32'h1, "R4 bit0 one keeps done");
    send_frame(4, 6, 2, 1'b0, "R8 error no irq");
    rd_chk(PING_ST, 32'h8, "R8 error no done");
    chk("R8 no drop counted", 32'(drop0), 32'd1);
    send_frame(5, 4, -1, 1'b1, "R8 same bank retry");
    rd_chk(PING_ST, 32'h9, "R8 next frame to ping");
    rd_chk(PING, ew(5, 4, 0), "R2 ping word");
  endtask

  task automatic t_trunc;
    bus_write(PING_ST, 32'h8);
    bus_write(PONG_ST, 32'h0);
    send_frame(6, 2050, -1, 1'b0, "R9 long frame");
    rd_chk(PONG_ST, 32'h1, "R9 long frame done");
    rd_chk(PONG, ew(6, 2050, 0), "R9 first word");
    rd_chk(PONG + 13'h7F8, ew(6, 2050, 510), "R9 last data word");
    send_frame(7, 8, -1, 1'b1, "R5 back to ping");
    rd_chk(PING + 13'd4, ew(7, 8, 1), "R5 ping after pong");
  endtask

  task automatic t_nopong;
    to1 = 1'b1;
    send_frame(8, 3, -1, 1'b0, "R6 first");
    rd_chk(PING_ST, 32'h1, "R6 ping done");
    rd_chk(PING, ew(8, 3, 0), "R6 ping data");
    bus_write(PING_ST, 32'h0);
    send_frame(9, 6, -1, 1'b0, "R6 second");
    rd_chk(PING_ST, 32'h1, "R6 second to ping");
    rd_chk(PING + 13'd4, ew(9, 6, 1), "R6 second data");
    bus_write(PONG_ST, 32'h9);
    rd_chk(PONG_ST, 32'h0, "R6 pong status zero");
    rd_chk(PONG, 32'h0, "R6 pong data zero");
    to1 = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_drop();
    t_ack_and_err();
    t_trunc();
    t_nopong();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule